// File: doc/BRIEF.md
# Palette and Mode Register Port

This block is the processor-facing register file of an enhanced video controller. It watches 16-bit I/O write and read requests and answers on two addresses. The first address is a write-only select port. The byte written there carries a 2-bit group in its top bits and a 6-bit sub-group below it. The second address is a data port that can be read and written. What a data access does depends on the group that was last selected.

The palette group selects one of 64 colour entries, each 8 bits wide. The mode group carries an enable flag for the enhanced palette in bit 0 of its data byte. In the same group, the select byte also mirrors a 3-bit screen mode and a 3-bit hi-res colour choice.

A second palette read port is asynchronous and read-only. The video pipeline uses it to look up colours while the processor side keeps working.

Top module: `palx_regport`

## Requirements
- R1: After a synchronous reset, the palette flag is 0. The screen mode and the hi-res colour are 0. All 64 entries read as 0x00. The selected group is palette and the selected index is 0, so a data read returns 0x00.
- R2: A request acts only when all 16 address bits match. The select port is 0xBF3B and the data port is 0xFF3B. Writes to any other address change nothing. Reads from any other address, and idle cycles, leave `io_rdata` at 0xFF.
- R3: A select write with bits 7:6 = 00 chooses the palette group, and bits 5:0 give the entry index. A following data write stores its byte in that entry.
- R4: While `io_rd` is high with the data-port address and the palette group selected, `io_rdata` shows the selected entry in the same cycle.
- R5: While the mode group (bits 7:6 = 01) is selected, a data write of 0x00 or 0x01 sets the palette flag to bit 0. Data values 0x02 to 0xFF are ignored.
- R6: A select write with bits 7:6 = 01 loads bits 2:0 into `scr_mode` and bits 5:3 into `hires_col`. Both take effect on the next cycle.
- R7: A data read while the mode group is selected returns 0x00 or 0x01, equal to the palette flag.
- R8: A select write with bits 7:6 = 10 or 11 selects a reserved group. It leaves the screen mode, hi-res colour, flag and entries unchanged. Data writes in a reserved group are ignored, and data reads return 0xFF.
- R9: `vid_color` always shows the entry at `vid_idx` combinationally. A new entry value shows from the cycle after the write, whatever the processor side is doing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 16 | I/O address |
| io_wr | input | 1 | I/O write strobe, one cycle per access |
| io_rd | input | 1 | I/O read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, 0xFF when not answering |
| vid_idx | input | 6 | Video lookup index |
| vid_color | output | 8 | Palette entry at vid_idx |
| pal_on | output | 1 | Enhanced palette enable flag |
| scr_mode | output | 3 | Mirrored screen mode |
| hires_col | output | 3 | Mirrored hi-res colour selection |

## Verification
The bench builds the block with its default parameters: a 16-bit address, 8-bit data and a 6-bit index. With these values all 64 entries can be written and read back through both read ports, including index 63. Every select-byte pattern that matters is reachable: both reserved groups, all mode-field bits, and the data values just above the valid flag values. The address tests use near-miss addresses that differ in only the high byte or only the low byte, which proves the full 16-bit compare.

// File: rtl/palx_pkg.sv
package palx_pkg;

    localparam int SEL_W = 8;
    localparam int GRP_W = 2;
    localparam int SUB_W = SEL_W - GRP_W;

    typedef enum logic [GRP_W-1:0] {
        GRP_PAL  = 2'b00,
        GRP_MODE = 2'b01,
        GRP_RES2 = 2'b10,
        GRP_RES3 = 2'b11
    } grp_e;

    typedef struct packed {
        logic sel_wr;
        logic data_wr;
        logic data_rd;
    } io_req_t;

    typedef struct packed {
        logic [2:0] hires;
        logic [2:0] scr;
    } mode_t;

    function automatic grp_e grp_of(input logic [SEL_W-1:0] b);
        return grp_e'(b[SEL_W-1 -: GRP_W]);
    endfunction

    function automatic logic grp_reserved(input grp_e g);
        return g[GRP_W-1];
    endfunction

    function automatic mode_t mode_of(input logic [SEL_W-1:0] b);
        mode_t m;
        m.scr   = b[2:0];
        m.hires = b[5:3];
        return m;
    endfunction

endpackage

// File: rtl/palx_decode.sv
module palx_decode
    import palx_pkg::*;
#(
    parameter int          ADDR_W    = 16,
    parameter logic [15:0] SEL_ADDR  = 16'hBF3B,
    parameter logic [15:0] DATA_ADDR = 16'hFF3B
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    output io_req_t           req
);

    logic hit_sel;
    logic hit_data;

    always_comb begin
        hit_sel      = (io_addr == SEL_ADDR[ADDR_W-1:0]);
        hit_data     = (io_addr == DATA_ADDR[ADDR_W-1:0]);
        req.sel_wr   = io_wr && hit_sel;
        req.data_wr  = io_wr && hit_data;
        req.data_rd  = io_rd && hit_data;
    end

    // R2
    decode_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({req.sel_wr, req.data_wr}));

endmodule

// File: rtl/palx_select.sv
module palx_select
    import palx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  io_req_t          req,
    input  logic [SEL_W-1:0] wdata,
    output grp_e             grp,
    output logic [SUB_W-1:0] idx,
    output mode_t            mode,
    output logic             pal_on
);

    grp_e  grp_q;
    logic [SUB_W-1:0] idx_q;
    mode_t mode_q;
    logic  on_q;
    grp_e  new_grp;
    logic  flag_ok;

    always_comb begin
        new_grp = grp_of(wdata);
        flag_ok = (wdata[SEL_W-1:1] == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            grp_q  <= GRP_PAL;
            idx_q  <= '0;
            mode_q <= '0;
            on_q   <= 1'b0;
        end else begin
            if (req.sel_wr) begin
                grp_q <= new_grp;
                unique case (new_grp)
                    GRP_PAL:  idx_q  <= wdata[SUB_W-1:0];
                    GRP_MODE: mode_q <= mode_of(wdata);
                    default:  ;
                endcase
            end
            if (req.data_wr && grp_q == GRP_MODE && flag_ok)
                on_q <= wdata[0];
        end
    end

    always_comb begin
        grp    = grp_q;
        idx    = idx_q;
        mode   = mode_q;
        pal_on = on_q;
    end

    // R6
    mode_load_chk: assert property (@(posedge clk) disable iff (rst)
        (req.sel_wr && wdata[7:6] == 2'b01) |=> (mode.hires == $past(wdata[5:3]) && mode.scr == $past(wdata[2:0])));

    // R8
    reserved_sel_chk: assert property (@(posedge clk) disable iff (rst)
        (req.sel_wr && wdata[7]) |=> ($stable(mode) && $stable(idx) && $stable(pal_on)));

    // R5
    flag_reject_chk: assert property (@(posedge clk) disable iff (rst)
        (req.data_wr && wdata > 8'h01) |=> $stable(pal_on));

    // R8
    reserved_data_chk: assert property (@(posedge clk) disable iff (rst)
        (req.data_wr && grp_reserved(grp)) |=> $stable(pal_on));

endmodule

// File: rtl/palx_mem.sv
module palx_mem #(
    parameter int IDX_W  = 6,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [IDX_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  cpu_addr,
    output logic [DATA_W-1:0] cpu_data,
    input  logic [IDX_W-1:0]  vid_addr,
    output logic [DATA_W-1:0] vid_data
);

    localparam int DEPTH = 1 << IDX_W;

    logic [DATA_W-1:0] ent [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) ent[i] <= '0;
        end else if (we) begin
            ent[waddr] <= wdata;
        end
    end

    always_comb begin
        cpu_data = ent[cpu_addr];
        vid_data = ent[vid_addr];
    end

    // R3
    entry_store_chk: assert property (@(posedge clk) disable iff (rst)
        we |=> ent[$past(waddr)] == $past(wdata));

endmodule

// File: rtl/palx_regport.sv
module palx_regport
    import palx_pkg::*;
#(
    parameter int          ADDR_W    = 16,
    parameter logic [15:0] SEL_ADDR  = 16'hBF3B,
    parameter logic [15:0] DATA_ADDR = 16'hFF3B
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [SEL_W-1:0]  io_wdata,
    output logic [SEL_W-1:0]  io_rdata,
    input  logic [SUB_W-1:0]  vid_idx,
    output logic [SEL_W-1:0]  vid_color,
    output logic              pal_on,
    output logic [2:0]        scr_mode,
    output logic [2:0]        hires_col
);

    localparam logic [SEL_W-1:0] IDLE_BYTE = '1;

    io_req_t          req;
    grp_e             grp;
    logic [SUB_W-1:0] idx;
    mode_t            mode;
    logic             mem_we;
    logic [SEL_W-1:0] cpu_entry;

    palx_decode #(
        .ADDR_W   (ADDR_W),
        .SEL_ADDR (SEL_ADDR),
        .DATA_ADDR(DATA_ADDR)
    ) u_dec (
        .clk    (clk),
        .rst    (rst),
        .io_addr(io_addr),
        .io_wr  (io_wr),
        .io_rd  (io_rd),
        .req    (req)
    );

    palx_select u_sel (
        .clk   (clk),
        .rst   (rst),
        .req   (req),
        .wdata (io_wdata),
        .grp   (grp),
        .idx   (idx),
        .mode  (mode),
        .pal_on(pal_on)
    );

    always_comb mem_we = req.data_wr && (grp == GRP_PAL);

    palx_mem #(
        .IDX_W (SUB_W),
        .DATA_W(SEL_W)
    ) u_mem (
        .clk     (clk),
        .rst     (rst),
        .we      (mem_we),
        .waddr   (idx),
        .wdata   (io_wdata),
        .cpu_addr(idx),
        .cpu_data(cpu_entry),
        .vid_addr(vid_idx),
        .vid_data(vid_color)
    );

    always_comb begin
        io_rdata = IDLE_BYTE;
        if (req.data_rd) begin
            unique case (grp)
                GRP_PAL:  io_rdata = cpu_entry;
                GRP_MODE: io_rdata = {{(SEL_W-1){1'b0}}, pal_on};
                default:  io_rdata = IDLE_BYTE;
            endcase
        end
        scr_mode  = mode.scr;
        hires_col = mode.hires;
    end

    // R2
    foreign_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (io_wr && io_addr != SEL_ADDR[ADDR_W-1:0] && io_addr != DATA_ADDR[ADDR_W-1:0])
        |=> ($stable(pal_on) && $stable(scr_mode) && $stable(hires_col)));

    // R7
    mode_read_chk: assert property (@(posedge clk) disable iff (rst)
        (req.data_rd && grp == GRP_MODE) |-> io_rdata[SEL_W-1:1] == '0);

endmodule

// File: tb/sim_palx_regport.sv
`timescale 1ns/100ps
module sim_palx_regport;

    localparam logic [15:0] SELP = 16'hBF3B;
    localparam logic [15:0] DATP = 16'hFF3B;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } rd_item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] io_addr = '0;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic [5:0]  vid_idx = '0;
    logic [7:0]  vid_color;
    logic        pal_on;
    logic [2:0]  scr_mode;
    logic [2:0]  hires_col;

    int n_cmp = 0;
    int n_bad = 0;
    rd_item_t q[$];

    logic [7:0] m_pal [64];
    logic [1:0] m_grp = 2'b00;
    logic [5:0] m_idx = '0;
    logic       m_on  = 1'b0;
    logic [2:0] m_scr = '0;
    logic [2:0] m_hi  = '0;

    always #2.5 clk = ~clk;

    palx_regport u0 (
        .clk(clk), .rst(rst), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .vid_idx(vid_idx),
        .vid_color(vid_color), .pal_on(pal_on), .scr_mode(scr_mode),
        .hires_col(hires_col)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // monitor: compares read data against the queue in mid-cycle
    always @(negedge clk) begin
        if (io_rd) begin
            if (q.size() == 0) begin
                n_cmp++; n_bad++;
                $display("FAIL R4: actual %02h expected none (empty queue)", io_rdata);
            end else begin
                rd_item_t it;
                it = q.pop_front();
                check(it.tag, io_rdata, it.exp);
            end
        end
    end

    function automatic logic [7:0] model_read(input logic [15:0] a);
        if (a != DATP) return 8'hFF;
        case (m_grp)
            2'b00:   return m_pal[m_idx];
            2'b01:   return {7'b0, m_on};
            default: return 8'hFF;
        endcase
    endfunction

    task automatic cpu_wr(input logic [15:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(posedge clk); #1;
        io_wr = 1'b0;
        if (a == SELP) begin
            m_grp = d[7:6];
            if (d[7:6] == 2'b00) m_idx = d[5:0];
            if (d[7:6] == 2'b01) begin m_scr = d[2:0]; m_hi = d[5:3]; end
        end else if (a == DATP) begin
            if (m_grp == 2'b00) m_pal[m_idx] = d;
            else if (m_grp == 2'b01 && d <= 8'h01) m_on = d[0];
        end
    endtask

    task automatic cpu_rd(input logic [15:0] a, input string tag);
        rd_item_t it;
        @(posedge clk); #1;
        it.exp = model_read(a);
        it.tag = tag;
        q.push_back(it);
        io_addr = a; io_rd = 1'b1;
        @(posedge clk); #1;
        io_rd = 1'b0;
    endtask

    task automatic check_status(input string tag);
        check({tag, " pal_on"}, {7'b0, pal_on}, {7'b0, m_on});
        check({tag, " scr_mode"}, {5'b0, scr_mode}, {5'b0, m_scr});
        check({tag, " hires_col"}, {5'b0, hires_col}, {5'b0, m_hi});
    endtask

    initial begin
        #(200000 * 5);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 64; i++) m_pal[i] = 8'h00;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        check_status("R1");
        check("R1 idle rdata", io_rdata, 8'hFF);
        vid_idx = 6'd63; #1;
        check("R1 vid entry 63", vid_color, 8'h00);
        cpu_rd(DATP, "R1 read entry 0");

        // R3 / R4 single entry
        cpu_wr(SELP, 8'h05);
        cpu_wr(DATP, 8'hA5);
        cpu_rd(DATP, "R4 read entry 5");
        vid_idx = 6'd5; #1;
        check("R9 vid entry 5", vid_color, 8'hA5);

        // R3 fill all entries
        for (int i = 0; i < 64; i++) begin
            cpu_wr(SELP, 8'(i));
            cpu_wr(DATP, 8'((i * 37) ^ 8'h5A));
        end
        for (int i = 0; i < 64; i += 9) begin
            cpu_wr(SELP, 8'(i));
            cpu_rd(DATP, "R3 R4 readback");
        end
        cpu_wr(SELP, 8'd63);
        cpu_rd(DATP, "R3 R4 readback entry 63");
        for (int i = 0; i < 64; i++) begin
            vid_idx = 6'(i); #1;
            check("R9 vid sweep", vid_color, m_pal[i]);
        end

        // R9 video lookup during a CPU write to another entry
        vid_idx = 6'd10;
        cpu_wr(SELP, 8'd20);
        @(posedge clk); #1;
        io_addr = DATP; io_wdata = 8'h3C; io_wr = 1'b1;
        #1 check("R9 vid during write", vid_color, m_pal[10]);
        vid_idx = 6'd20; #1;
        check("R9 vid before commit", vid_color, m_pal[20]);
        @(posedge clk); #1;
        io_wr = 1'b0; m_pal[20] = 8'h3C;
        check("R9 vid after commit", vid_color, 8'h3C);

        // R6 mode select fields
        cpu_wr(SELP, 8'h5E);
        check_status("R6 mode 5E");
        cpu_wr(SELP, 8'h41);
        check_status("R6 mode 41");

        // R5 / R7 flag
        cpu_rd(DATP, "R7 flag read off");
        cpu_wr(DATP, 8'h01);
        check_status("R5 flag on");
        cpu_rd(DATP, "R7 flag read on");
        cpu_wr(DATP, 8'h02);
        check_status("R5 value 02 ignored");
        cpu_wr(DATP, 8'hFE);
        check_status("R5 value FE ignored");
        cpu_rd(DATP, "R7 flag still on");

        // R8 reserved groups
        cpu_wr(SELP, 8'hBF);
        check_status("R8 select 10");
        cpu_wr(DATP, 8'h00);
        check_status("R8 data in group 10");
        cpu_rd(DATP, "R8 read group 10");
        cpu_wr(SELP, 8'hC7);
        cpu_wr(DATP, 8'h33);
        check_status("R8 group 11");
        cpu_rd(DATP, "R8 read group 11");
        cpu_wr(SELP, 8'd20);
        cpu_rd(DATP, "R8 entry untouched");

        // R2 near-miss addresses
        cpu_wr(16'hBF3A, 8'h47);
        cpu_wr(16'h3F3B, 8'h47);
        check_status("R2 foreign select");
        cpu_wr(16'hFF3C, 8'h99);
        cpu_wr(16'hFE3B, 8'h99);
        cpu_rd(DATP, "R2 entry 20 after foreign writes");
        cpu_rd(16'hBF3B, "R2 select port read");
        cpu_rd(16'h7F3B, "R2 foreign read");

        // R1 reset again clears state
        @(posedge clk); #1 rst = 1'b1;
        @(posedge clk); #1 rst = 1'b0;
        for (int i = 0; i < 64; i++) m_pal[i] = 8'h00;
        m_grp = 2'b00; m_idx = '0; m_on = 1'b0; m_scr = '0; m_hi = '0;
        check_status("R1 re-reset");
        vid_idx = 6'd20; #1;
        check("R1 entry cleared", vid_color, 8'h00);

        repeat (2) @(posedge clk);
        if (q.size() != 0) begin
            n_cmp++; n_bad++;
            $display("FAIL R4: actual %0d pending expected 0", q.size());
        end
        finish_run();
    end

endmodule